// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a high-precision event timer. It watches a free-running main counter supplied from outside and raises an interrupt when that counter equals a programmed comparator value. Software programs the channel through two write ports: one carries a configuration word and the other a comparator value. A third strobe clears the sticky status bit. Matching takes place only while the shared counter-enable input is high.

The channel runs in one-shot mode or in periodic mode. In periodic mode a stored period is added to the comparator after each match. A self-clearing load-select bit lets software place the first comparator value and then the period through the same write port. A 32-bit mode restricts the comparison and the comparator arithmetic to the low 32 bits. The interrupt is either a one-cycle pulse or a level held by a status bit that software clears. Comparator writes pass through a short internal pipeline before they reach the match logic.

Top module: `evt_cmp_channel`

## Requirements
- R1: The channel fires only on a clock edge where the counter equals the comparator exactly. A target that the counter has already passed does not fire until the counter comes round to it again.
- R2: In one-shot mode a match fires once and leaves the comparator unchanged.
- R3: In periodic mode with the load-select bit (config bit 3) set, a comparator write loads the comparator and clears bit 3. A write with bit 3 clear loads the period and leaves the comparator unchanged.
- R4: In periodic mode (config bit 1) each enabled match adds the stored period to the comparator, so the counter values that fire are spaced by the period.
- R5: With config bit 4 set, only the low 32 bits of the counter and the comparator are compared. Comparator loads and periodic advances wrap modulo 2^32 and leave the upper bits zero.
- R6: A comparator write appears on `cmp_rdata`, and in the match logic, WR_DLY clock edges after the edge that captured it, and not earlier.
- R7: Config readback holds enable (bit 0), periodic (1), level (2), load-select (3), 32-bit (4), periodic capability (5) and message capability (6). Bits 5 to 7 ignore writes: bits 5 and 6 return the PER_CAP and MSG_CAP parameters and bit 7 reads 0.
- R8: While enable (bit 0) is clear, no interrupt is raised and the comparator keeps its value, with no periodic advance.
- R9: In level mode (bit 2 set), a match sets `sts_o` and `irq_o` follows it. Both stay high until a cycle with `sts_clr` high.
- R10: In edge mode (bit 2 clear), each match drives `irq_o` high for exactly one clock, and `sts_o` stays low.
- R11: While `cnt_en` is low, no match takes place even if the counter equals the comparator.
- R12: After reset, the config readback shows only the capability bits, and the comparator, `irq_o` and `sts_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Config word write strobe |
| cfg_wdata | input | 8 | Config word write data |
| cfg_rdata | output | 8 | Config word readback including capability bits |
| cmp_we | input | 1 | Comparator port write strobe |
| cmp_wdata | input | CNT_W | Comparator or period write data |
| cmp_rdata | output | CNT_W | Active comparator value |
| sts_clr | input | 1 | Clears the level-mode status bit |
| sts_o | output | 1 | Level-mode interrupt status |
| cnt_en | input | 1 | Global counter-enable; gates matching |
| cnt | input | CNT_W | Main counter value |
| irq_o | output | 1 | Channel interrupt |

## Verification
The match function is driven with several counter sweeps. A sweep across a future target shows that the channel fires once and at the right value. A sweep started beyond the target shows that the test is equality, not greater-or-equal. A sweep across a 32-bit rollover with nonzero upper counter bits shows that the upper bits are ignored. A periodic sweep records the values that fire and so tells a correct period from an off-by-one reload. The periodic sweep across 2^32 exposes a reload that carries into the upper bits. Repeated sweeps with the channel disabled and with `cnt_en` low each separate the two gates from the match itself. Readbacks taken one edge at a time after a comparator write fix the length of the write delay.

// File: rtl/evt_cmp_pkg.sv
package evt_cmp_pkg;

  localparam int CFG_W     = 8;
  localparam int B_EN      = 0;
  localparam int B_PER     = 1;
  localparam int B_LVL     = 2;
  localparam int B_SETV    = 3;
  localparam int B_W32     = 4;
  localparam int B_CAP_PER = 5;
  localparam int B_CAP_MSG = 6;

  typedef enum logic {
    LD_CMP = 1'b0,
    LD_PER = 1'b1
  } ld_kind_e;

  typedef struct packed {
    logic en;
    logic per;
    logic lvl;
    logic setv;
    logic w32;
  } chan_cfg_t;

endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sh_q <= '0;
    else           sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sh_q[STAGES-1];

endmodule

// File: rtl/evt_wr_pipe.sv
module evt_wr_pipe
  import evt_cmp_pkg::*;
#(
  parameter int DW    = 64,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  ld_kind_e      in_kind,
  input  logic [DW-1:0] in_data,
  output logic          out_vld,
  output ld_kind_e      out_kind,
  output logic [DW-1:0] out_data
);

  for (genvar s = 0; s < DEPTH; s++) begin : g_stg
    logic          pv;
    ld_kind_e      pk;
    logic [DW-1:0] pd;
    logic          vq;
    ld_kind_e      kq;
    logic [DW-1:0] dq;

    if (s == 0) begin : g_head
      assign pv = in_vld;
      assign pk = in_kind;
      assign pd = in_data;
    end else begin : g_body
      assign pv = g_stg[s-1].vq;
      assign pk = g_stg[s-1].kq;
      assign pd = g_stg[s-1].dq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vq <= 1'b0;
      else        vq <= pv;
    end

    // payload flops carry no reset; they load only with a valid beat
    always_ff @(posedge clk) begin
      if (pv) begin
        kq <= pk;
        dq <= pd;
      end
    end
  end

  assign out_vld  = g_stg[DEPTH-1].vq;
  assign out_kind = g_stg[DEPTH-1].kq;
  assign out_data = g_stg[DEPTH-1].dq;

endmodule

// File: rtl/evt_match.sv
module evt_match
  import evt_cmp_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_vld,
  input  ld_kind_e         ld_kind,
  input  logic [CNT_W-1:0] ld_data,
  input  logic             w32,
  input  logic             per_mode,
  input  logic             arm,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmp_q,
  output logic             hit
);

  logic [CNT_W-1:0] cmp_d;
  logic [CNT_W-1:0] per_q;
  logic [CNT_W-1:0] per_d;
  logic [CNT_W-1:0] sum;
  logic [CNT_W-1:0] ld_val;
  logic             eq;

  if (CNT_W > 32) begin : g_wide
    localparam int HI_W = CNT_W - 32;
    logic [31:0] lo_sum;
    assign lo_sum = cmp_q[31:0] + per_q[31:0];
    assign eq     = w32 ? (cnt[31:0] == cmp_q[31:0]) : (cnt == cmp_q);
    assign sum    = w32 ? {{HI_W{1'b0}}, lo_sum} : (cmp_q + per_q);
    assign ld_val = w32 ? {{HI_W{1'b0}}, ld_data[31:0]} : ld_data;
  end else begin : g_narrow
    logic unused_w32;
    assign unused_w32 = w32;
    assign eq     = (cnt == cmp_q);
    assign sum    = cmp_q + per_q;
    assign ld_val = ld_data;
  end

  assign hit = arm & eq;

  always_comb begin
    cmp_d = cmp_q;
    per_d = per_q;
    if (ld_vld && ld_kind == LD_PER) per_d = ld_data;
    if (ld_vld && ld_kind == LD_CMP) cmp_d = ld_val;
    else if (hit && per_mode)        cmp_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      per_q <= '0;
    end else begin
      cmp_q <= cmp_d;
      per_q <= per_d;
    end
  end

  // R8: without a load or an enabled match the comparator holds
  p_cmp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_vld && !hit) |=> $stable(cmp_q));

  // R4: a periodic match in full-width mode advances by the period
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && per_mode && !w32 && !ld_vld) |=> (cmp_q == $past(cmp_q) + $past(per_q)));

endmodule

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel
  import evt_cmp_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int WR_DLY  = 2,
  parameter bit PER_CAP = 1'b1,
  parameter bit MSG_CAP = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             cmp_we,
  input  logic [CNT_W-1:0] cmp_wdata,
  output logic [CNT_W-1:0] cmp_rdata,
  input  logic             sts_clr,
  output logic             sts_o,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] cnt,
  output logic             irq_o
);

  logic       rst_n_s;
  chan_cfg_t  cfg_q, cfg_d;
  logic       sts_q, sts_d;
  logic       pulse_q, pulse_d;
  ld_kind_e   wr_kind;
  logic       pl_vld;
  ld_kind_e   pl_kind;
  logic [CNT_W-1:0] pl_data;
  logic       hit;
  logic       unused_cfg;

  assign unused_cfg = ^cfg_wdata[CFG_W-1:B_W32+1];

  evt_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  // config register: next state
  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      cfg_d.en   = cfg_wdata[B_EN];
      cfg_d.per  = cfg_wdata[B_PER] & PER_CAP;
      cfg_d.lvl  = cfg_wdata[B_LVL];
      cfg_d.setv = cfg_wdata[B_SETV];
      cfg_d.w32  = cfg_wdata[B_W32];
    end else if (cmp_we) begin
      cfg_d.setv = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) cfg_q <= '0;
    else          cfg_q <= cfg_d;
  end

  assign cfg_rdata = {1'b0, MSG_CAP, PER_CAP, cfg_q.w32, cfg_q.setv,
                      cfg_q.lvl, cfg_q.per, cfg_q.en};

  // a write in periodic mode with load-select clear targets the period
  assign wr_kind = (cfg_q.per && !cfg_q.setv) ? LD_PER : LD_CMP;

  evt_wr_pipe #(.DW(CNT_W), .DEPTH(WR_DLY)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .in_vld   (cmp_we),
    .in_kind  (wr_kind),
    .in_data  (cmp_wdata),
    .out_vld  (pl_vld),
    .out_kind (pl_kind),
    .out_data (pl_data)
  );

  evt_match #(.CNT_W(CNT_W)) u_match (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .ld_vld   (pl_vld),
    .ld_kind  (pl_kind),
    .ld_data  (pl_data),
    .w32      (cfg_q.w32),
    .per_mode (cfg_q.per),
    .arm      (cnt_en & cfg_q.en),
    .cnt      (cnt),
    .cmp_q    (cmp_rdata),
    .hit      (hit)
  );

  // interrupt output: next state
  always_comb begin
    sts_d   = cfg_q.lvl & (hit | (sts_q & ~sts_clr));
    pulse_d = ~cfg_q.lvl & hit;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sts_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      sts_q   <= sts_d;
      pulse_q <= pulse_d;
    end
  end

  assign sts_o = sts_q;
  assign irq_o = sts_q | pulse_q;

  // R11: the global enable gates every match
  p_gate_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cnt_en |-> !hit);

  // R8: a disabled channel raises no new interrupt
  p_quiet_off_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!cfg_q.en && !irq_o && !cfg_we) |=> !irq_o);

  // R9: level status holds until cleared
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sts_q && cfg_q.lvl && !sts_clr && !cfg_we) |=> sts_q);

  // R10: an edge-mode interrupt comes only from a match one edge earlier
  p_edge_src_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (irq_o && !cfg_q.lvl && !$past(cfg_q.lvl)) |-> $past(hit));

  // R3: load-select clears after a comparator write
  p_setv_clear_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cfg_q.setv && cmp_we && !cfg_we) |=> !cfg_q.setv);

endmodule

// File: tb/evt_cmp_channel_bench.sv
module evt_cmp_channel_bench;

  localparam int CNT_W  = 64;
  localparam int WR_DLY = 2;

  logic             clk;
  logic             rst_n;
  logic             cfg_we;
  logic [7:0]       cfg_wdata;
  logic [7:0]       cfg_rdata;
  logic             cmp_we;
  logic [CNT_W-1:0] cmp_wdata;
  logic [CNT_W-1:0] cmp_rdata;
  logic             sts_clr;
  logic             sts_o;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt;
  logic             irq_o;

  int          n_chk;
  int          n_fail;
  int          nhits;
  logic [63:0] hit_log [4];
  logic        run;
  logic        done;

  // 8 time units per period: the 125 MHz counter clock
  initial clk = 1'b0;
  always #4 clk = ~clk;

  evt_cmp_channel #(.CNT_W(CNT_W), .WR_DLY(WR_DLY), .PER_CAP(1'b1), .MSG_CAP(1'b0)) u_evt_cmp_channel (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .cmp_we    (cmp_we),
    .cmp_wdata (cmp_wdata),
    .cmp_rdata (cmp_rdata),
    .sts_clr   (sts_clr),
    .sts_o     (sts_o),
    .cnt_en    (cnt_en),
    .cnt       (cnt),
    .irq_o     (irq_o)
  );

  // one negedge: log the interrupt seen for the current count, then advance
  task automatic tick();
    @(negedge clk);
    if (irq_o === 1'b1) begin
      if (nhits < 4) hit_log[nhits] = cnt;
      nhits++;
    end
    if (run) cnt = cnt + 1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    cfg_wdata = v;
    cfg_we    = 1'b1;
    tick();
    cfg_we    = 1'b0;
  endtask

  task automatic wr_cmp(input logic [63:0] v);
    cmp_wdata = v;
    cmp_we    = 1'b1;
    tick();
    cmp_we    = 1'b0;
  endtask

  task automatic sweep(input logic [63:0] start, input int n);
    run   = 1'b0;
    cnt   = start;
    nhits = 0;
    run   = 1'b1;
    ticks(n);
    run   = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 cfg", {56'd0, cfg_rdata}, 64'h20);
    chk("R12 cmp", cmp_rdata, 64'h0);
    chk("R12 irq", {63'd0, irq_o}, 64'h0);
    chk("R12 sts", {63'd0, sts_o}, 64'h0);
  endtask

  task automatic t_oneshot();
    cnt = 0;
    wr_cmp(64'd20);
    chk("R6 before", cmp_rdata, 64'h0);
    for (int i = 1; i < WR_DLY; i++) begin
      tick();
      chk("R6 before", cmp_rdata, 64'h0);
    end
    tick();
    chk("R6 after", cmp_rdata, 64'd20);
    wr_cfg(8'h01);
    sweep(64'd0, 40);
    chk("R1 count", nhits, 1);
    chk("R10 one clock", nhits, 1);
    chk("R1 value", hit_log[0], 64'd20);
    chk("R2 cmp kept", cmp_rdata, 64'd20);
  endtask

  task automatic t_passed_and_wrap();
    cnt = 64'd40;
    wr_cmp(64'd10);
    ticks(WR_DLY + 1);
    sweep(64'd40, 30);
    chk("R1 passed target", nhits, 0);
    cnt = 64'h1_FFFF_FFF0;
    wr_cfg(8'h11);
    wr_cmp(64'd5);
    ticks(WR_DLY + 1);
    sweep(64'h1_FFFF_FFF0, 30);
    chk("R5 count", nhits, 1);
    chk("R5 value", hit_log[0], 64'h2_0000_0005);
    chk("R5 cmp", cmp_rdata, 64'd5);
  endtask

  task automatic t_periodic();
    cnt = 64'd100;
    wr_cfg(8'h0B);
    wr_cmp(64'd110);
    chk("R3 setv cleared", {56'd0, cfg_rdata}, 64'h23);
    ticks(WR_DLY + 1);
    wr_cmp(64'd7);
    ticks(WR_DLY + 1);
    chk("R3 cmp kept", cmp_rdata, 64'd110);
    sweep(64'd100, 26);
    chk("R4 count", nhits, 3);
    chk("R4 first", hit_log[0], 64'd110);
    chk("R4 second", hit_log[1], 64'd117);
    chk("R4 third", hit_log[2], 64'd124);
    chk("R4 next cmp", cmp_rdata, 64'd131);
  endtask

  task automatic t_periodic_w32();
    cnt = 64'hFFFF_FFF0;
    wr_cfg(8'h1B);
    wr_cmp(64'hFFFF_FFF8);
    ticks(WR_DLY + 1);
    wr_cmp(64'h10);
    ticks(WR_DLY + 1);
    sweep(64'hFFFF_FFF0, 30);
    chk("R5 reload count", nhits, 2);
    chk("R5 reload first", hit_log[0], 64'hFFFF_FFF8);
    chk("R5 reload second", hit_log[1], 64'h1_0000_0008);
    chk("R5 reload cmp", cmp_rdata, 64'h18);
  endtask

  task automatic t_disable();
    cnt = 64'h10;
    wr_cfg(8'h02);
    sweep(64'h10, 20);
    chk("R8 no irq", nhits, 0);
    chk("R8 cmp kept", cmp_rdata, 64'h18);
    cnt = 64'h10;
    wr_cfg(8'h03);
    sweep(64'h10, 20);
    chk("R8 re-enabled count", nhits, 1);
    chk("R8 re-enabled value", hit_log[0], 64'h18);
    chk("R4 advance", cmp_rdata, 64'h28);
  endtask

  task automatic t_cnt_gate();
    cnt_en = 1'b0;
    sweep(64'h20, 15);
    chk("R11 no irq", nhits, 0);
    chk("R11 cmp kept", cmp_rdata, 64'h28);
    cnt_en = 1'b1;
  endtask

  task automatic t_level();
    cnt = 64'h40;
    wr_cfg(8'h00);
    wr_cmp(64'h50);
    ticks(WR_DLY + 1);
    wr_cfg(8'h05);
    sweep(64'h40, 30);
    chk("R9 sts held", {63'd0, sts_o}, 64'h1);
    chk("R9 irq held", {63'd0, irq_o}, 64'h1);
    sts_clr = 1'b1;
    tick();
    sts_clr = 1'b0;
    chk("R9 sts cleared", {63'd0, sts_o}, 64'h0);
    chk("R9 irq cleared", {63'd0, irq_o}, 64'h0);
  endtask

  task automatic t_caps();
    wr_cfg(8'hFF);
    chk("R7 all ones", {56'd0, cfg_rdata}, 64'h3F);
    wr_cfg(8'h00);
    chk("R7 all zeros", {56'd0, cfg_rdata}, 64'h20);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    done      = 1'b0;
    n_chk     = 0;
    n_fail    = 0;
    nhits     = 0;
    run       = 1'b0;
    rst_n     = 1'b0;
    cfg_we    = 1'b0;
    cfg_wdata = '0;
    cmp_we    = 1'b0;
    cmp_wdata = '0;
    sts_clr   = 1'b0;
    cnt_en    = 1'b1;
    cnt       = '0;
    ticks(3);
    rst_n = 1'b1;
    ticks(4);
    t_reset();
    t_oneshot();
    t_passed_and_wrap();
    t_periodic();
    t_periodic_w32();
    t_disable();
    t_cnt_gate();
    t_level();
    t_caps();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule